// File: doc/BRIEF.md
# Boot-Time Register Restore Engine

After the device has been configured, this block brings its user registers to a working state without help from software. A pulse on `start` opens a read of a reserved region of an SPI serial flash. That region is kept apart from the configuration image. The block streams a prepared list of register entries out of the flash and plays each one onto an internal register bus as a write. It then reports either completion or failure. The settings list is produced and programmed into the flash by other means; this block only reads and replays it.

Each entry in the flash is six bytes long: a 16-bit register address followed by a 32-bit value, both with the most significant byte first. An entry whose address is all ones ends the list. Only addresses in the upper half of the register space (0x8000 and above) are written. Lower addresses are passed over and counted. Each write holds its strobe until the bus acknowledges it. A bus that stays silent for too long stops the replay with an error.

Top module: `cfgr_restore_top`

## Requirements
- R1: While reset is high and after it is released: `spi_cs_n` is 1, `spi_sck` is 0, `bus_stb` is 0, both flags are 0 and `skip_count` is 0.
- R2: After a `start` pulse, chip select goes low and the first 32 bits on `spi_mosi` are the read opcode 0x03 followed by the 24-bit region base `FLASH_BASE`, MSB first. The SPI clock is mode 0: it idles low, the master samples MISO on the rising edge, and MOSI changes only while SCK is low.
- R3: Each list entry (address in bytes 0–1, data in bytes 2–5, big-endian) whose address is 0x8000 or above causes exactly one bus write carrying that address and data. Writes happen in list order, and the bus never sees an address below 0x8000.
- R4: An entry whose address is below 0x8000 causes no bus write and adds one to `skip_count`.
- R5: An entry with address 0xFFFF ends the replay. `restore_done` rises, `spi_cs_n` returns high, and the end entry produces no write and no skip.
- R6: `bus_stb` stays high with `bus_addr` and `bus_wdata` unchanged until `bus_ack` is seen.
- R7: If no acknowledge arrives within `ACK_TIMEOUT` (1024) cycles of strobe, the strobe drops after exactly that many cycles. `restore_err` is then set, `spi_cs_n` returns high, and no further writes follow.
- R8: Once `MAX_ENTRIES` (256) entries have been handled (written or skipped) without an end entry, `restore_done` rises. No later entry is written.
- R9: `restore_done` and `restore_err` are never high together and hold until the next accepted `start`. A `start` during a replay is ignored; a `start` after completion or failure clears both flags and replays again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a replay (pulse) |
| spi_sck | output | 1 | SPI serial clock to the flash |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| bus_addr | output | 16 | Register write address |
| bus_wdata | output | 32 | Register write data |
| bus_stb | output | 1 | Write strobe, held until acknowledged |
| bus_ack | input | 1 | Write acknowledge from the register bus |
| restore_done | output | 1 | Replay finished normally |
| restore_err | output | 1 | Replay aborted by an acknowledge timeout |
| skip_count | output | 9 | Entries passed over for being below the user range |

## Verification
The hardest case to reach is the entry-count limit. It needs a flash image with no end entry that runs past 256 entries. It also needs a bus that acknowledges reliably for the whole run, so that the limit, and not a timeout, ends it. The bench fills its flash model with 300 entries that alternate between user-range and low addresses. It pulses `start` partway through and then checks that the replay stopped at entry 255, with exactly 128 writes and 128 skips. The timeout case is reached by a bus model that withholds its acknowledge. The bench measures the strobe width in cycles.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_WRITE,
    ST_DONE,
    ST_ERR
  } cfgr_state_e;

  localparam logic [7:0] FLASH_READ_OP = 8'h03;
  localparam int         HDR_BYTES     = 4;

endpackage

// File: rtl/cfgr_spi_byte.sv
module cfgr_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  output logic [7:0] rx,
  output logic       done,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DVW = (HALF > 1) ? $clog2(HALF) : 1;

  logic           busy;
  logic [DVW-1:0] div;
  logic [2:0]     bitn;
  logic [7:0]     sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      div  <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
      done <= 1'b0;
      sck  <= 1'b0;
      mosi <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          div  <= '0;
          bitn <= '0;
          sh   <= tx;
          mosi <= tx[7];
          sck  <= 1'b0;
        end
      end else if (div == DVW'(HALF - 1)) begin
        div <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);                                   // R2
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));                            // R2

endmodule

// File: rtl/cfgr_bus_wr.sv
module cfgr_bus_wr #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int TIMEOUT = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          ack,
  output logic          stb,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          ok,
  output logic          tout
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb  <= 1'b0;
      addr <= '0;
      data <= '0;
      tmr  <= '0;
      ok   <= 1'b0;
      tout <= 1'b0;
    end else begin
      ok   <= 1'b0;
      tout <= 1'b0;
      if (!stb) begin
        if (req) begin
          stb  <= 1'b1;
          addr <= in_addr;
          data <= in_data;
          tmr  <= '0;
        end
      end else if (ack) begin
        stb <= 1'b0;
        ok  <= 1'b1;
      end else if (tmr == TW'(TIMEOUT - 1)) begin
        stb  <= 1'b0;
        tout <= 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  AST_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stb && !ack && tmr != TW'(TIMEOUT - 1)) |=> (stb && $stable(addr) && $stable(data))); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(ok && tout));                                    // R7

endmodule

// File: rtl/cfgr_restore_top.sv
module cfgr_restore_top #(
  parameter logic [23:0] FLASH_BASE  = 24'h3F0000,
  parameter int          SCK_HALF    = 2,
  parameter int          ACK_TIMEOUT = 1024,
  parameter int          MAX_ENTRIES = 256,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_stb,
  input  logic              bus_ack,
  output logic              restore_done,
  output logic              restore_err,
  output logic [CNT_W-1:0]  skip_count
);
  import cfgr_pkg::*;

  localparam int ENT_W     = ADDR_W + DATA_W;
  localparam int ENT_BYTES = ENT_W / 8;
  localparam int IDX_W     = $clog2(ENT_BYTES + 1);
  localparam logic [ADDR_W-1:0] USER_MIN = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] END_MARK = {ADDR_W{1'b1}};

  cfgr_state_e       state;
  logic [IDX_W-1:0]  idx;
  logic              wait_b;
  logic [ENT_W-1:0]  ent_buf;
  logic [ENT_W-1:0]  ent_next;
  logic [ADDR_W-1:0] addr_next;
  logic [CNT_W-1:0]  ent_cnt;
  logic              wr_req;
  logic              last_ent;

  logic       byte_go;
  logic [7:0] byte_tx;
  logic [7:0] byte_rx;
  logic       byte_done;
  logic       wr_ok;
  logic       wr_tout;

  always_comb begin
    byte_go   = (state == ST_HDR || state == ST_DATA) && !wait_b;
    ent_next  = {ent_buf[ENT_W-9:0], byte_rx};
    addr_next = ent_next[ENT_W-1 -: ADDR_W];
    last_ent  = (ent_cnt == CNT_W'(MAX_ENTRIES - 1));
    case (idx)
      IDX_W'(0): byte_tx = FLASH_READ_OP;
      IDX_W'(1): byte_tx = FLASH_BASE[23:16];
      IDX_W'(2): byte_tx = FLASH_BASE[15:8];
      default:   byte_tx = FLASH_BASE[7:0];
    endcase
    if (state == ST_DATA) byte_tx = 8'h00;
  end

  cfgr_spi_byte #(.HALF(SCK_HALF)) u_spi (
    .clk  (clk),
    .rst  (rst),
    .go   (byte_go),
    .tx   (byte_tx),
    .rx   (byte_rx),
    .done (byte_done),
    .sck  (spi_sck),
    .mosi (spi_mosi),
    .miso (spi_miso)
  );

  cfgr_bus_wr #(.AW(ADDR_W), .DW(DATA_W), .TIMEOUT(ACK_TIMEOUT)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .req     (wr_req),
    .in_addr (ent_buf[ENT_W-1 -: ADDR_W]),
    .in_data (ent_buf[DATA_W-1:0]),
    .ack     (bus_ack),
    .stb     (bus_stb),
    .addr    (bus_addr),
    .data    (bus_wdata),
    .ok      (wr_ok),
    .tout    (wr_tout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      idx          <= '0;
      wait_b       <= 1'b0;
      ent_buf      <= '0;
      ent_cnt      <= '0;
      wr_req       <= 1'b0;
      spi_cs_n     <= 1'b1;
      restore_done <= 1'b0;
      restore_err  <= 1'b0;
      skip_count   <= '0;
    end else begin
      wr_req <= 1'b0;
      if (byte_go) wait_b <= 1'b1;
      case (state)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start) begin
            state        <= ST_HDR;
            spi_cs_n     <= 1'b0;
            idx          <= '0;
            wait_b       <= 1'b0;
            ent_cnt      <= '0;
            skip_count   <= '0;
            restore_done <= 1'b0;
            restore_err  <= 1'b0;
          end
        end
        ST_HDR: begin
          if (byte_done) begin
            wait_b <= 1'b0;
            if (idx == IDX_W'(HDR_BYTES - 1)) begin
              idx   <= '0;
              state <= ST_DATA;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (byte_done) begin
            wait_b  <= 1'b0;
            ent_buf <= ent_next;
            if (idx == IDX_W'(ENT_BYTES - 1)) begin
              idx <= '0;
              if (addr_next == END_MARK) begin
                state        <= ST_DONE;
                spi_cs_n     <= 1'b1;
                restore_done <= 1'b1;
              end else if (addr_next < USER_MIN) begin
                skip_count <= skip_count + 1'b1;
                ent_cnt    <= ent_cnt + 1'b1;
                if (last_ent) begin
                  state        <= ST_DONE;
                  spi_cs_n     <= 1'b1;
                  restore_done <= 1'b1;
                end
              end else begin
                wr_req <= 1'b1;
                state  <= ST_WRITE;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (wr_ok) begin
            ent_cnt <= ent_cnt + 1'b1;
            if (last_ent) begin
              state        <= ST_DONE;
              spi_cs_n     <= 1'b1;
              restore_done <= 1'b1;
            end else begin
              state <= ST_DATA;
            end
          end else if (wr_tout) begin
            state       <= ST_ERR;
            spi_cs_n    <= 1'b1;
            restore_err <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_USER_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> (bus_addr >= USER_MIN));               // R3
  AST_SKIP_STEP: assert property (@(posedge clk) disable iff (rst)
    (skip_count != $past(skip_count)) |-> (skip_count == $past(skip_count) + 1'b1 || skip_count == '0)); // R4
  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (rst)
    restore_done |-> spi_cs_n);                        // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    restore_err |-> (spi_cs_n && !bus_stb));           // R7
  AST_SKIP_CAP: assert property (@(posedge clk) disable iff (rst)
    skip_count <= CNT_W'(MAX_ENTRIES));                // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(restore_done && restore_err));                   // R9
  AST_CS_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);                            // R2

endmodule

// File: tb/cfgr_restore_top_tb.sv
module cfgr_restore_top_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [23:0] BASE       = 24'h3F0000;
  localparam int          TOUT       = 1024;
  localparam int          MAXE       = 256;
  localparam int          WD_CYCLES  = 190000;

  localparam int NVEC = 8;
  localparam logic [47:0] VEC [NVEC] = '{
    48'h8000_00000001,
    48'h8001_DEADBEEF,
    48'h1234_55555555,
    48'hFFFE_A5A5A5A5,
    48'h7FFF_11111111,
    48'h8000_CAFEF00D,
    48'hC3C3_0000FFFF,
    48'hFFFF_00000000
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        sck, cs_n, mosi;
  logic        miso = 1'b0;
  logic [15:0] baddr;
  logic [31:0] bdata;
  logic        stb;
  logic        ack = 1'b0;
  logic        done, err;
  logic [8:0]  skipc;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfgr_restore_top #(.FLASH_BASE(BASE), .ACK_TIMEOUT(TOUT), .MAX_ENTRIES(MAXE)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .bus_addr(baddr), .bus_wdata(bdata), .bus_stb(stb), .bus_ack(ack),
    .restore_done(done), .restore_err(err), .skip_count(skipc)
  );

  // flash model, SPI mode 0
  logic [7:0]  fmem [0:2047];
  int          fbit = 0;
  logic [31:0] hdr = '0;

  always @(negedge cs_n) begin
    fbit = 0;
    hdr  = '0;
  end
  always @(posedge sck) begin
    if (!cs_n) begin
      if (fbit < 32) hdr = {hdr[30:0], mosi};
      fbit = fbit + 1;
    end
  end
  always @(negedge sck) begin
    if (!cs_n && fbit >= 32) begin
      int p;
      p = fbit - 32;
      miso = fmem[(p / 8) % 2048][7 - (p % 8)];
    end
  end

  // register bus model
  int          ack_delay_mode = 1;
  logic        no_ack = 1'b0;
  int          acnt = 0;
  int          wr_n = 0;
  logic [15:0] log_a [0:511];
  logic [31:0] log_d [0:511];
  logic        stb_q = 1'b0;
  logic [15:0] hold_a = '0;
  logic [31:0] hold_d = '0;
  int          viol = 0;
  int          stb_len = 0;

  always @(posedge clk) begin
    stb_q <= stb;
    if (stb && !stb_q) begin
      hold_a  <= baddr;
      hold_d  <= bdata;
      stb_len <= 1;
    end else if (stb) begin
      stb_len <= stb_len + 1;
      if (baddr != hold_a || bdata != hold_d) viol <= viol + 1;
    end
    ack <= 1'b0;
    if (stb && !ack) begin
      if (!no_ack) begin
        if (acnt >= (wr_n * ack_delay_mode) % 5) begin
          ack            <= 1'b1;
          log_a[wr_n % 512] <= baddr;
          log_d[wr_n % 512] <= bdata;
          wr_n           <= wr_n + 1;
          acnt           <= 0;
        end else begin
          acnt <= acnt + 1;
        end
      end
    end else begin
      acnt <= 0;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_entry(input int i, input logic [47:0] e);
    for (int k = 0; k < 6; k++) fmem[i * 6 + k] = e[47 - 8 * k -: 8];
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    for (int c = 0; c < 80000; c++) begin
      @(negedge clk);
      if (done || err) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int base, exp_n, exp_skip;
    for (int i = 0; i < 2048; i++) fmem[i] = 8'hFF;

    // reset state
    repeat (4) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && stb == 0, "R1 bus/spi idle in reset", {cs_n, sck, stb}, 3'b100);
    @(negedge clk) rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && stb == 0 && !done && !err && skipc == 0, "R1 idle after reset",
        {cs_n, sck, stb, done, err, skipc}, {1'b1, 13'h0});

    // table-driven replay
    for (int i = 0; i < NVEC; i++) put_entry(i, VEC[i]);
    base = wr_n;
    pulse_start();
    wait_end();
    chk(hdr == {8'h03, BASE}, "R2 read opcode and base", hdr, {8'h03, BASE});
    chk(done && !err, "R5 done after end entry", {done, err}, 2'b10);
    chk(cs_n == 1 && sck == 0, "R5 chip select released", {cs_n, sck}, 2'b10);
    exp_n = 0;
    exp_skip = 0;
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][47:32] == 16'hFFFF) break;
      if (VEC[i][47:32] >= 16'h8000) begin
        chk(log_a[base + exp_n] == VEC[i][47:32] && log_d[base + exp_n] == VEC[i][31:0],
            "R3 write content and order", {log_a[base + exp_n], log_d[base + exp_n]}, VEC[i]);
        exp_n++;
      end else begin
        exp_skip++;
      end
    end
    chk(wr_n - base == exp_n, "R3 write count", wr_n - base, exp_n);
    chk(skipc == 9'(exp_skip), "R4 skipped entries counted", skipc, exp_skip);
    chk(viol == 0, "R6 strobe held stable until ack", viol, 0);

    // end marker first
    put_entry(0, 48'hFFFF_12345678);
    base = wr_n;
    pulse_start();
    wait_end();
    chk(done && wr_n == base && skipc == 0, "R5 immediate end entry",
        {done, 32'(wr_n - base), skipc}, {1'b1, 41'h0});

    // acknowledge timeout
    put_entry(0, 48'h9000_0BADF00D);
    put_entry(1, 48'h9001_00000002);
    put_entry(2, 48'hFFFF_00000000);
    no_ack = 1'b1;
    base = wr_n;
    pulse_start();
    wait_end();
    chk(err && !done, "R7 error flag on timeout", {err, done}, 2'b10);
    chk(stb_len == TOUT, "R7 strobe width equals timeout", stb_len, TOUT);
    chk(!stb && cs_n, "R7 bus and flash released", {stb, cs_n}, 2'b01);
    repeat (50) @(negedge clk);
    chk(wr_n == base && !stb, "R7 no writes after abort", wr_n - base, 0);

    // restart after failure
    no_ack = 1'b0;
    base = wr_n;
    pulse_start();
    @(negedge clk);
    chk(!err && !done, "R9 start clears flags", {err, done}, 2'b00);
    wait_end();
    chk(done && !err && wr_n - base == 2 && log_a[base + 1] == 16'h9001, "R9 replay after error",
        {done, err, 32'(wr_n - base)}, {2'b10, 32'd2});

    // entry-count limit, no end marker, start pulse mid-run
    for (int i = 0; i < 300; i++)
      put_entry(i, (i % 2 == 0) ? {16'(16'h8000 + i), 32'(i)} : {16'h0001, 32'(i)});
    ack_delay_mode = 3;
    base = wr_n;
    pulse_start();
    repeat (5000) @(negedge clk);
    pulse_start();
    wait_end();
    chk(done && !err, "R8 done at entry limit", {done, err}, 2'b10);
    chk(wr_n - base == 128, "R8 write count at limit", wr_n - base, 128);
    chk(skipc == 9'd128, "R8 skip count at limit", skipc, 128);
    chk(log_a[base + 127] == 16'h80FE && log_d[base + 127] == 32'd254, "R8 last written entry",
        {log_a[base + 127], log_d[base + 127]}, {16'h80FE, 32'd254});
    chk(log_a[base + 2] == 16'h8004, "R9 mid-run start ignored", log_a[base + 2], 16'h8004);

    // reset mid-run
    pulse_start();
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cs_n && !sck && !stb && !done && !err && skipc == 0, "R1 reset aborts replay",
        {cs_n, sck, stb, done, err, skipc}, {1'b1, 13'h0});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule